// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract Unit

This unit performs the accumulator arithmetic of an 8-bit processor core. It handles add-with-carry and subtract-with-borrow. It works either on plain binary bytes or on packed two-digit decimal (BCD) bytes. A variant select picks between the older NMOS flag behaviour and the later CMOS flag behaviour. The surrounding core supplies the accumulator, the fetched operand, the carry flag, the decimal-mode flag and a one-cycle `start` pulse. The unit returns the new accumulator and the negative, zero, overflow and carry flags, all held in registers.

Decimal mode in the CMOS variant costs one more cycle, which the core spends on a dummy read. The unit marks that case on `extra_cyc`. It raises `done` once the result may be consumed. The NMOS variant keeps its decimal-mode quirks bit for bit. Some of its flags come from the uncorrected intermediate sum or from the plain binary result. Operands that are not valid BCD still give a fixed, well-defined result.

Top module: `bcd_addsub_unit`

## Requirements
- R1: Binary add (`op_sub`=0, `dec_en`=0) gives `acc_out` = low 8 bits of A+M+C. `c_out`=1 exactly when A+M+C > 0xFF.
- R2: Binary add sets `v_out` when A and M share bit 7 and the result's bit 7 differs from M's. `n_out` is result bit 7, and `z_out` is 1 when the result is zero.
- R3: Binary subtract (`op_sub`=1) gives `acc_out` = low 8 bits of A−M−(1−C). `c_out`=1 when no borrow occurs. `v_out`=1 when A differs in bit 7 from both the result and M. N and Z follow the result.
- R4: Decimal add in both variants works in three steps. First, low digit L = A[3:0]+M[3:0]+C. If L ≥ 0x0A, it becomes ((L+6)&0xF)+0x10. Second, T = A[7:4]·16 + M[7:4]·16 + L. Third, if T ≥ 0xA0, 0x60 is added. `acc_out` = T[7:0], and `c_out` = (T ≥ 0x100). `v_out` follows the R2 rule, applied to T before the 0x60 step.
- R5: In NMOS decimal add, `n_out` is bit 7 of T before the 0x60 step. `z_out` is 1 when the low byte of the binary A+M+C is zero.
- R6: NMOS decimal subtract works in three steps. First, low digit L = A[3:0]−M[3:0]−(1−C). If L < 0, it becomes ((L−6)&0xF)−0x10. Second, T = (A&0xF0)−(M&0xF0)+L. Third, if T < 0, 0x60 is subtracted. `acc_out` = T[7:0]. N, Z, V and C all equal those of binary subtract.
- R7: CMOS decimal subtract starts from the full binary difference D. It subtracts 0x60 if D < 0, and 0x06 if the low-digit difference is negative. `acc_out` is the low byte of the outcome. V and C come from binary subtract, while N and Z come from `acc_out`.
- R8: In CMOS decimal add, `n_out` and `z_out` come from the final `acc_out`.
- R9: For binary operations and for NMOS decimal operations, `done` is high in the cycle after the `start` edge and `extra_cyc` is 0.
- R10: For CMOS decimal operations (`cmos_sel`=1, `dec_en`=1), `extra_cyc` is 1 and `done` is low in the cycle after the `start` edge, then high in the cycle after that.
- R11: A `start` pulse that arrives while an extra cycle is pending is ignored: the outputs keep the pending result.
- R12: After reset, `acc_out`, all flags, `extra_cyc` and `done` are 0.
- R13: Non-BCD digit values (A–F) follow the R4, R6 and R7 rules with no special case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one operation this edge |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_en | input | 1 | Decimal (BCD) mode |
| cmos_sel | input | 1 | 0 = NMOS flag behaviour, 1 = CMOS behaviour |
| a_in | input | 8 | Accumulator value |
| m_in | input | 8 | Operand value |
| c_in | input | 1 | Incoming carry flag |
| acc_out | output | 8 | New accumulator |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |
| extra_cyc | output | 1 | The last operation needed one extra cycle |
| done | output | 1 | Result may be consumed |

## Verification
The result and flags are registered on the `start` edge, so they can be checked one cycle after that edge in every mode. `done` appears in that same cycle for binary and NMOS decimal operations. For CMOS decimal operations it comes one cycle later. Each test drives inputs at the falling edge and samples at the following falling edges. It checks `done` low first and high second whenever the extra cycle applies. A second `start` sent during the pending cycle checks that the held result survives.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;
   localparam int NIB_W  = 4;
   localparam int DIGITS = 2;
   localparam int BYTE_W = NIB_W * DIGITS;

   typedef struct packed {
      logic [BYTE_W-1:0] res;
      logic              n;
      logic              z;
      logic              v;
      logic              c;
   } alu_out_t;
endpackage

// File: rtl/bcd_bin_core.sv
module bcd_bin_core
   import bcd_addsub_pkg::*;
#(
   parameter int W = BYTE_W
) (
   input  logic         sub,
   input  logic [W-1:0] a,
   input  logic [W-1:0] m,
   input  logic         cin,
   output alu_out_t     y,
   output logic [W-1:0] sum_lo
);
   localparam int EW = W + 2;
   logic [EW-1:0] s_add, s_sub;

   always_comb begin
      s_add = EW'(a) + EW'(m) + EW'(cin);
      s_sub = EW'(a) - EW'(m) - EW'(!cin);
      sum_lo = s_add[W-1:0];
      if (!sub) begin
         y.res = s_add[W-1:0];
         y.c   = s_add[W];
         y.v   = ~(a[W-1] ^ m[W-1]) & (m[W-1] ^ s_add[W-1]);
      end else begin
         y.res = s_sub[W-1:0];
         y.c   = ~s_sub[EW-1];
         y.v   = (a[W-1] ^ s_sub[W-1]) & (a[W-1] ^ m[W-1]);
      end
      y.n = y.res[W-1];
      y.z = (y.res == '0);
   end

   // R3: a cleared carry on subtract means the minuend was smaller
   always_comb begin
      if (!$isunknown({sub, a, m, cin, y.c}) && sub)
         a_r3_borrow: assert (y.c == ((W+1)'(a) >= (W+1)'(m) + (W+1)'(!cin)));
   end
endmodule

// File: rtl/bcd_dec_add.sv
module bcd_dec_add
   import bcd_addsub_pkg::*;
#(
   parameter bit CMOS = 1'b0
) (
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] m,
   input  logic              cin,
   input  logic [BYTE_W-1:0] bin_sum,
   output alu_out_t          y
);
   logic [NIB_W:0]     lo_raw, lo_fix;
   logic [NIB_W-1:0]   lo_inc;
   logic [BYTE_W+1:0]  mid, fin;

   always_comb begin
      lo_raw = {1'b0, a[NIB_W-1:0]} + {1'b0, m[NIB_W-1:0]} + (NIB_W+1)'(cin);
      lo_inc = lo_raw[NIB_W-1:0] + NIB_W'(6);
      lo_fix = (lo_raw >= (NIB_W+1)'(10)) ? {1'b1, lo_inc} : lo_raw;
      mid = (BYTE_W+2)'({a[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
          + (BYTE_W+2)'({m[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
          + (BYTE_W+2)'(lo_fix);
      fin = (mid >= (BYTE_W+2)'(8'hA0)) ? mid + (BYTE_W+2)'(8'h60) : mid;
      y.res = fin[BYTE_W-1:0];
      y.c   = |fin[BYTE_W+1:BYTE_W];
      y.v   = ~(a[BYTE_W-1] ^ m[BYTE_W-1]) & (m[BYTE_W-1] ^ mid[BYTE_W-1]);
   end

   generate
      if (CMOS) begin : g_cmos
         assign y.n = fin[BYTE_W-1];
         assign y.z = (fin[BYTE_W-1:0] == '0);
      end else begin : g_nmos
         assign y.n = mid[BYTE_W-1];
         assign y.z = (bin_sum == '0);
      end
   endgenerate
endmodule

// File: rtl/bcd_dec_sub.sv
module bcd_dec_sub
   import bcd_addsub_pkg::*;
#(
   parameter bit CMOS = 1'b0
) (
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] m,
   input  logic              cin,
   input  alu_out_t          bin,
   output alu_out_t          y
);
   localparam int SW = BYTE_W + 3;
   logic signed [SW-1:0] lo_d, full_d;
   logic signed [SW-1:0] fin;

   always_comb begin
      lo_d   = SW'(a[NIB_W-1:0]) - SW'(m[NIB_W-1:0]) - SW'(!cin);
      full_d = SW'(a) - SW'(m) - SW'(!cin);
   end

   generate
      if (CMOS) begin : g_cmos
         logic signed [SW-1:0] t1;
         always_comb begin
            t1  = full_d[SW-1] ? full_d - SW'(8'h60) : full_d;
            fin = lo_d[SW-1] ? t1 - SW'(6) : t1;
            y.res = fin[BYTE_W-1:0];
            y.n   = fin[BYTE_W-1];
            y.z   = (fin[BYTE_W-1:0] == '0);
            y.v   = bin.v;
            y.c   = bin.c;
         end
      end else begin : g_nmos
         logic signed [SW-1:0] lo_fix, lo_m6, t1;
         always_comb begin
            lo_m6  = lo_d - SW'(6);
            lo_fix = lo_d[SW-1] ? SW'(lo_m6[NIB_W-1:0]) - SW'(16) : lo_d;
            t1  = SW'({a[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
                - SW'({m[BYTE_W-1:NIB_W], {NIB_W{1'b0}}}) + lo_fix;
            fin = t1[SW-1] ? t1 - SW'(8'h60) : t1;
            y.res = fin[BYTE_W-1:0];
            y.n   = bin.n;
            y.z   = bin.z;
            y.v   = bin.v;
            y.c   = bin.c;
         end
      end
   endgenerate
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
   import bcd_addsub_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_sub,
   input  logic              dec_en,
   input  logic              cmos_sel,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] m_in,
   input  logic              c_in,
   output logic [DATA_W-1:0] acc_out,
   output logic              n_out,
   output logic              z_out,
   output logic              v_out,
   output logic              c_out,
   output logic              extra_cyc,
   output logic              done
);
   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("bcd_addsub_unit: DATA_W must equal two 4-bit digits");
      end
   endgenerate

   alu_out_t             bin_y, dadd_n, dadd_c, dsub_n, dsub_c, sel_y, q;
   logic [BYTE_W-1:0]    bin_sum;
   logic                 need_extra, pend, accept;

   bcd_bin_core #(.W(BYTE_W)) u_bin (
      .sub(op_sub), .a(a_in), .m(m_in), .cin(c_in), .y(bin_y), .sum_lo(bin_sum));

   bcd_dec_add #(.CMOS(1'b0)) u_dadd_n (
      .a(a_in), .m(m_in), .cin(c_in), .bin_sum(bin_sum), .y(dadd_n));
   bcd_dec_add #(.CMOS(1'b1)) u_dadd_c (
      .a(a_in), .m(m_in), .cin(c_in), .bin_sum(bin_sum), .y(dadd_c));
   bcd_dec_sub #(.CMOS(1'b0)) u_dsub_n (
      .a(a_in), .m(m_in), .cin(c_in), .bin(bin_y), .y(dsub_n));
   bcd_dec_sub #(.CMOS(1'b1)) u_dsub_c (
      .a(a_in), .m(m_in), .cin(c_in), .bin(bin_y), .y(dsub_c));

   always_comb begin
      unique case ({dec_en, op_sub, cmos_sel})
         3'b100:  sel_y = dadd_n;
         3'b101:  sel_y = dadd_c;
         3'b110:  sel_y = dsub_n;
         3'b111:  sel_y = dsub_c;
         default: sel_y = bin_y;
      endcase
      need_extra = dec_en & cmos_sel;
      accept     = start & ~pend;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q         <= '0;
         pend      <= 1'b0;
         done      <= 1'b0;
         extra_cyc <= 1'b0;
      end else if (accept) begin
         q         <= sel_y;
         pend      <= need_extra;
         done      <= ~need_extra;
         extra_cyc <= need_extra;
      end else if (pend) begin
         pend <= 1'b0;
         done <= 1'b1;
      end else begin
         done <= 1'b0;
      end
   end

   assign acc_out = q.res;
   assign n_out   = q.n;
   assign z_out   = q.z;
   assign v_out   = q.v;
   assign c_out   = q.c;

   a_r9_done_next: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !pend && !(dec_en && cmos_sel)) |=> (done && !extra_cyc));
   a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !pend && dec_en && cmos_sel) |=> (!done && extra_cyc));
   a_r10_finish: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> done);
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> ($stable(acc_out) && $stable(c_out) && $stable(v_out)));
endmodule

// File: tb/bcd_addsub_unit_test.sv
module bcd_addsub_unit_test;
   logic clk = 1'b0;
   logic rst_n, start, op_sub, dec_en, cmos_sel, c_in;
   logic [7:0] a_in, m_in, acc_out;
   logic n_out, z_out, v_out, c_out, extra_cyc, done;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   bcd_addsub_unit uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Returns {acc[7:0], n, z, v, c}
   function automatic logic [11:0] model(input int a, input int m, input int c,
                                         input bit sub, input bit dec, input bit cm);
      int bs, bd, r, lo, t, n, z, v, cy;
      bs = a + m + c;
      bd = a - m - (1 - c);
      if (!sub && !dec) begin
         r = bs & 255; cy = (bs > 255);
         v = (((a ^ m) & 128) == 0) && (((m ^ bs) & 128) != 0);
         n = (r >> 7) & 1; z = (r == 0);
      end else if (sub && !dec) begin
         r = bd & 255; cy = (bd >= 0);
         v = (((a ^ bd) & 128) != 0) && (((a ^ m) & 128) != 0);
         n = (r >> 7) & 1; z = (r == 0);
      end else if (!sub) begin
         lo = (a & 15) + (m & 15) + c;
         if (lo >= 10) lo = ((lo + 6) & 15) + 16;
         t = (a & 240) + (m & 240) + lo;
         v = (((a ^ m) & 128) == 0) && (((m ^ t) & 128) != 0);
         if (cm) begin
            if (t >= 160) t = t + 96;
            r = t & 255; n = (r >> 7) & 1; z = (r == 0);
         end else begin
            n = (t >> 7) & 1; z = ((bs & 255) == 0);
            if (t >= 160) t = t + 96;
            r = t & 255;
         end
         cy = (t >= 256);
      end else begin
         v = (((a ^ bd) & 128) != 0) && (((a ^ m) & 128) != 0);
         cy = (bd >= 0);
         lo = (a & 15) - (m & 15) - (1 - c);
         if (cm) begin
            t = bd;
            if (t < 0) t = t - 96;
            if (lo < 0) t = t - 6;
            r = t & 255; n = (r >> 7) & 1; z = (r == 0);
         end else begin
            if (lo < 0) lo = ((lo - 6) & 15) - 16;
            t = (a & 240) - (m & 240) + lo;
            if (t < 0) t = t - 96;
            r = t & 255; n = ((bd & 255) >> 7) & 1; z = ((bd & 255) == 0);
         end
      end
      return {r[7:0], n[0], z[0], v[0], cy[0]};
   endfunction

   task automatic run(input string req, input int a, input int m, input int c,
                      input bit sub, input bit dec, input bit cm);
      logic [11:0] exp;
      bit ext;
      exp = model(a, m, c, sub, dec, cm);
      ext = dec && cm;
      @(negedge clk);
      a_in = a[7:0]; m_in = m[7:0]; c_in = c[0];
      op_sub = sub; dec_en = dec; cmos_sel = cm; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({req, " value"}, 32'({acc_out, n_out, z_out, v_out, c_out}), 32'(exp));
      chk({ext ? "R10" : "R9", " extra_cyc"}, 32'(extra_cyc), 32'(ext));
      chk({ext ? "R10" : "R9", " done first"}, 32'(done), 32'(!ext));
      if (ext) begin
         @(negedge clk);
         chk("R10 done second", 32'(done), 32'(1));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; start = 1'b0; op_sub = 0; dec_en = 0; cmos_sel = 0;
      c_in = 0; a_in = 0; m_in = 0;
      repeat (3) @(negedge clk);
      chk("R12 reset outs",
          32'({acc_out, n_out, z_out, v_out, c_out, extra_cyc, done}), 32'(0));
      rst_n = 1'b1;
   endtask

   task automatic t_bin();
      run("R1", 8'hFF, 8'h01, 0, 0, 0, 0);
      run("R2", 8'h50, 8'h50, 0, 0, 0, 1);
      run("R2", 8'h7F, 8'h00, 1, 0, 0, 0);
      run("R3", 8'h50, 8'hF0, 1, 1, 0, 0);
      run("R3", 8'h00, 8'h01, 1, 1, 0, 1);
      run("R3", 8'h80, 8'h01, 1, 1, 0, 0);
   endtask

   task automatic t_dec();
      for (int cm = 0; cm < 2; cm++) begin
         run(cm ? "R8" : "R5", 8'h99, 8'h01, 0, 0, 1, cm[0]);
         run("R4", 8'h58, 8'h46, 1, 0, 1, cm[0]);
         run("R13", 8'h0F, 8'hFF, 0, 0, 1, cm[0]);
         run(cm ? "R7" : "R6", 8'h00, 8'h01, 1, 1, 1, cm[0]);
         run(cm ? "R7" : "R6", 8'h46, 8'h12, 1, 1, 1, cm[0]);
         run("R13", 8'h1A, 8'h0B, 0, 1, 1, cm[0]);
      end
   endtask

   task automatic t_ignore();
      logic [11:0] exp;
      exp = model(8'h25, 8'h38, 0, 0, 1, 1);
      @(negedge clk);
      a_in = 8'h25; m_in = 8'h38; c_in = 0; op_sub = 0; dec_en = 1; cmos_sel = 1;
      start = 1'b1;
      @(negedge clk);
      a_in = 8'hFF; m_in = 8'hFF; c_in = 1; dec_en = 0;
      @(negedge clk);
      start = 1'b0;
      chk("R11 held value", 32'({acc_out, n_out, z_out, v_out, c_out}), 32'(exp));
      chk("R11 done", 32'(done), 32'(1));
      @(negedge clk);
      chk("R11 no late result", 32'(done), 32'(0));
   endtask

   initial begin
      t_reset();
      t_bin();
      t_dec();
      t_ignore();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule